// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer Counter

This block is a 16-bit up-counter with two compare registers, one external event input and a toggling output. A 3-bit mode field in a small control register chooses one of four counting behaviours. The counter can be stopped and held at zero. It can run free and wrap. It can clear and restart whenever the count reaches compare register 0. It can clear and restart on a valid edge of the external input. The same mode code also chooses whether the output reacts only to compare matches, or to compare matches and input edges.

Counting advances only on a count-enable strobe, which an external prescaler supplies. The external input passes through a two-flop synchronizer. A 2-bit selector then chooses which of its edges counts as valid.

A one-cycle interrupt pulse follows every compare match. A sticky overflow flag records each wrap from FFFFH to 0000H. Software loads the registers through a single-cycle write port. The control register can be read back at any time.

Top module: `mtimer16`

## Requirements
- R1: After reset, `ctrl_rd` is 00H, `count` is 0, and both `tout` and `irq` are 0.
- R2: In stop mode (mode 000, and the unused codes 011 and 111), `count` is cleared to 0 on the next clock and held there, and `irq` stays 0 even when the count equals a compare value.
- R3: In free-running modes (001, 010), `count` increments by one on each clock where `cnt_en` is 1, holds while `cnt_en` is 0, and wraps from FFFFH to 0000H.
- R4: In compare-clear modes (100, 101), a clock with `cnt_en` high while `count` equals compare register 0 loads `count` with 0 instead of incrementing.
- R5: In edge-clear mode (110), a valid edge loads `count` with 0 regardless of `cnt_en`. A change on `ext_in` driven before clock edge k shows as `count`==0 after clock edge k+2.
- R6: The edge select register (address 3, bits 1:0) encodes 00 falling, 01 rising, 10 no valid edge, 11 both edges. Its reset value is 00.
- R7: `irq` is high for one cycle after each clock where `cnt_en` is 1, the timer runs, and `count` equals compare register 0 (address 1) or compare register 1 (address 2).
- R8: `tout` toggles once in the cycle after a compare match in any running mode. In modes 010 and 101 it also toggles after a valid edge. Two events in the same clock give one toggle, and `tout` holds while stopped.
- R9: Overflow flag `ctrl_rd[0]` is set when `count` is FFFFH on a clock with `cnt_en` high in a running mode, including compare-clear with compare register 0 at FFFFH. The flag stays set until cleared, and setting wins over clearing.
- R10: A control write (address 0) with bit 0 low clears the overflow flag at any time. The mode field `ctrl_rd[3:1]` takes `wr_data[3:1]` while stopped. While running, only the stop code is accepted, and other codes are ignored. Bits 7:4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_addr | input | 2 | Register select: 0 control, 1 compare 0, 2 compare 1, 3 edge select |
| wr_data | input | 16 | Write data |
| cnt_en | input | 1 | Count-enable strobe from the prescaler |
| ext_in | input | 1 | Asynchronous external event input |
| count | output | 16 | Current counter value |
| ctrl_rd | output | 8 | Control register: bit 0 overflow, bits 3:1 mode |
| tout | output | 1 | Timer output, toggles on selected events |
| irq | output | 1 | One-cycle match interrupt pulse |

## Verification
Most internal faults in this block reach `count` within a cycle or two. A wrong mode decode or next-state priority shows as a count that fails to clear, or that keeps climbing in stop. A bad compare path shows as a missing or extra `irq` pulse in the cycle right after the match, with `tout` out of phase from then on. A fault in the synchronizer or edge select moves the edge-driven clear or toggle away from the third clock after the input change. An overflow fault only shows after a full 65536-count run, so that case is driven to the wrap explicitly.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

    localparam int CNT_W  = 16;
    localparam int ADDR_W = 2;
    localparam int CTRL_W = 8;
    localparam int NCMP   = 2;
    localparam int SYNC_N = 2;

    typedef enum logic [2:0] {
        MD_STOP    = 3'b000,
        MD_FREE_M  = 3'b001,
        MD_FREE_ME = 3'b010,
        MD_RSV3    = 3'b011,
        MD_CMP_M   = 3'b100,
        MD_CMP_ME  = 3'b101,
        MD_EDGE_M  = 3'b110,
        MD_RSV7    = 3'b111
    } mode_e;

    typedef enum logic [1:0] {
        EV_FALL = 2'b00,
        EV_RISE = 2'b01,
        EV_NONE = 2'b10,
        EV_BOTH = 2'b11
    } esel_e;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_CMP0 = 2'd1,
        RA_CMP1 = 2'd2,
        RA_ESEL = 2'd3
    } raddr_e;

    typedef enum logic [1:0] {
        CLR_NONE = 2'd0,
        CLR_CMP  = 2'd1,
        CLR_EDGE = 2'd2
    } clr_e;

    typedef struct packed {
        logic running;
        clr_e clr;
        logic edge_out;
    } mode_dec_t;

    typedef struct packed {
        mode_e mode;
        logic  ovf;
    } ctrl_t;

    function automatic mode_dec_t decode_mode(mode_e m);
        mode_dec_t d;
        d = '{running: 1'b0, clr: CLR_NONE, edge_out: 1'b0};
        case (m)
            MD_FREE_M:  d = '{running: 1'b1, clr: CLR_NONE, edge_out: 1'b0};
            MD_FREE_ME: d = '{running: 1'b1, clr: CLR_NONE, edge_out: 1'b1};
            MD_CMP_M:   d = '{running: 1'b1, clr: CLR_CMP,  edge_out: 1'b0};
            MD_CMP_ME:  d = '{running: 1'b1, clr: CLR_CMP,  edge_out: 1'b1};
            MD_EDGE_M:  d = '{running: 1'b1, clr: CLR_EDGE, edge_out: 1'b0};
            default:    d = '{running: 1'b0, clr: CLR_NONE, edge_out: 1'b0};
        endcase
        return d;
    endfunction

    function automatic logic [CTRL_W-1:0] pack_ctrl(ctrl_t c);
        return {{(CTRL_W-4){1'b0}}, c.mode, c.ovf};
    endfunction

endpackage

// File: rtl/mtimer_regs.sv
module mtimer_regs
    import mtimer_pkg::*;
#(
    parameter int W = CNT_W,
    parameter int N = NCMP
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [W-1:0]          wr_data,
    input  logic                  ovf_set,
    output ctrl_t                 ctrl,
    output logic [N-1:0][W-1:0]   cmp,
    output esel_e                 esel
);

    mode_e     wr_mode;
    mode_dec_t cur_dec;
    logic      wr_ctrl;
    logic      mode_ok;

    assign wr_ctrl = wr_en && (raddr_e'(wr_addr) == RA_CTRL);
    assign wr_mode = mode_e'(wr_data[3:1]);
    assign cur_dec = decode_mode(ctrl.mode);
    assign mode_ok = !cur_dec.running || (wr_mode == MD_STOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '{mode: MD_STOP, ovf: 1'b0};
        end else begin
            if (wr_ctrl && mode_ok)
                ctrl.mode <= wr_mode;
            if (ovf_set)
                ctrl.ovf <= 1'b1;
            else if (wr_ctrl && !wr_data[0])
                ctrl.ovf <= 1'b0;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_cmp_reg
        always_ff @(posedge clk) begin
            if (rst)
                cmp[g] <= '0;
            else if (wr_en && (int'(wr_addr) == int'(RA_CMP0) + g))
                cmp[g] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            esel <= EV_FALL;
        else if (wr_en && (raddr_e'(wr_addr) == RA_ESEL))
            esel <= esel_e'(wr_data[1:0]);
    end

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(ctrl.ovf) && !$past(wr_ctrl && !wr_data[0])) |-> ctrl.ovf);

    assert_mode_lock_R10: assert property (@(posedge clk) disable iff (rst)
        (cur_dec.running && !(wr_ctrl && wr_mode == MD_STOP)) |=> ctrl.mode == $past(ctrl.mode));

endmodule

// File: rtl/mtimer_edge.sv
module mtimer_edge
    import mtimer_pkg::*;
#(
    parameter int STAGES = SYNC_N
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    input  esel_e esel,
    output logic  edge_evt
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              rise;
    logic              fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            prev_q <= sync_q[LAST];
        end
    end

    assign rise = sync_q[LAST] && !prev_q;
    assign fall = !sync_q[LAST] && prev_q;

    always_comb begin
        case (esel)
            EV_FALL: edge_evt = fall;
            EV_RISE: edge_evt = rise;
            EV_BOTH: edge_evt = rise || fall;
            default: edge_evt = 1'b0;
        endcase
    end

    assert_edge_level_R6: assert property (@(posedge clk) disable iff (rst)
        (edge_evt && esel == EV_RISE) |=> prev_q);

    assert_edge_none_R6: assert property (@(posedge clk) disable iff (rst)
        (esel == EV_NONE) |-> !edge_evt);

endmodule

// File: rtl/mtimer_core.sv
module mtimer_core
    import mtimer_pkg::*;
#(
    parameter int W = CNT_W,
    parameter int N = NCMP
) (
    input  logic                 clk,
    input  logic                 rst,
    input  mode_dec_t            dec,
    input  logic                 cnt_en,
    input  logic                 edge_evt,
    input  logic [N-1:0][W-1:0]  cmp,
    output logic [W-1:0]         cnt_q,
    output logic                 irq_q,
    output logic                 tout_q,
    output logic                 ovf_set
);

    logic [N-1:0] hit;
    logic         any_hit;
    logic         edge_clr;
    logic         tog;
    logic [W-1:0] cnt_d;

    for (genvar g = 0; g < N; g++) begin : g_match
        assign hit[g] = dec.running && cnt_en && (cnt_q == cmp[g]);
    end

    assign any_hit  = |hit;
    assign edge_clr = dec.running && (dec.clr == CLR_EDGE) && edge_evt;
    assign ovf_set  = dec.running && cnt_en && (cnt_q == {W{1'b1}});
    assign tog      = any_hit || (dec.running && dec.edge_out && edge_evt);

    always_comb begin
        cnt_d = cnt_q;
        if (!dec.running)
            cnt_d = '0;
        else if (edge_clr)
            cnt_d = '0;
        else if (cnt_en) begin
            if ((dec.clr == CLR_CMP) && hit[0])
                cnt_d = '0;
            else
                cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            irq_q  <= 1'b0;
            tout_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            irq_q  <= any_hit;
            tout_q <= tout_q ^ tog;
        end
    end

    assert_stop_clear_R2: assert property (@(posedge clk) disable iff (rst)
        !dec.running |=> (cnt_q == '0));

    assert_stop_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !dec.running |=> !irq_q);

    assert_free_step_R3: assert property (@(posedge clk) disable iff (rst)
        (dec.running && dec.clr == CLR_NONE && cnt_en) |=> cnt_q == $past(cnt_q) + 1'b1);

    assert_cmp_restart_R4: assert property (@(posedge clk) disable iff (rst)
        (dec.running && dec.clr == CLR_CMP && cnt_en && cnt_q == cmp[0]) |=> cnt_q == '0);

    assert_tout_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !dec.running |=> $stable(tout_q));

endmodule

// File: rtl/mtimer16.sv
module mtimer16
    import mtimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              cnt_en,
    input  logic              ext_in,
    output logic [15:0]       count,
    output logic [7:0]        ctrl_rd,
    output logic              tout,
    output logic              irq
);

    ctrl_t                        ctrl;
    logic [NCMP-1:0][CNT_W-1:0]   cmp;
    esel_e                        esel;
    mode_dec_t                    dec;
    logic                         edge_evt;
    logic                         ovf_set;

    assign dec     = decode_mode(ctrl.mode);
    assign ctrl_rd = pack_ctrl(ctrl);

    mtimer_regs #(.W(CNT_W), .N(NCMP)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ovf_set (ovf_set),
        .ctrl    (ctrl),
        .cmp     (cmp),
        .esel    (esel)
    );

    mtimer_edge #(.STAGES(SYNC_N)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .din      (ext_in),
        .esel     (esel),
        .edge_evt (edge_evt)
    );

    mtimer_core #(.W(CNT_W), .N(NCMP)) u_core (
        .clk      (clk),
        .rst      (rst),
        .dec      (dec),
        .cnt_en   (cnt_en),
        .edge_evt (edge_evt),
        .cmp      (cmp),
        .cnt_q    (count),
        .irq_q    (irq),
        .tout_q   (tout),
        .ovf_set  (ovf_set)
    );

endmodule

// File: tb/mtimer16_tb.sv
`timescale 1ns/1ps
module mtimer16_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        cnt_en = 1'b0;
    logic        ext_in = 1'b0;
    logic [15:0] count;
    logic [7:0]  ctrl_rd;
    logic        tout;
    logic        irq;

    localparam int S_CNT = 0, S_TOUT = 1, S_IRQ = 2, S_CTRL = 3;

    typedef struct {
        int          cyc;
        int          sel;
        logic [15:0] exp;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    int   t0;

    mtimer16 u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_en(cnt_en), .ext_in(ext_in), .count(count), .ctrl_rd(ctrl_rd),
        .tout(tout), .irq(irq)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] observe(int sel);
        case (sel)
            S_CNT:  return count;
            S_TOUT: return {15'b0, tout};
            S_IRQ:  return {15'b0, irq};
            default: return {8'b0, ctrl_rd};
        endcase
    endfunction

    function automatic string sel_name(int sel);
        case (sel)
            S_CNT:  return "count";
            S_TOUT: return "tout";
            S_IRQ:  return "irq";
            default: return "ctrl_rd";
        endcase
    endfunction

    // monitor: pops expected items when their cycle is reached
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
                exp_t e;
                logic [15:0] got;
                e = sbq.pop_front();
                got = observe(e.sel);
                n_chk++;
                if (got !== e.exp) begin
                    n_fail++;
                    $display("FAIL %s %s at cycle %0d: actual=%h expected=%h",
                             e.tag, sel_name(e.sel), cyc, got, e.exp);
                end
            end
        end
    end

    task automatic push(int dly, int sel, logic [15:0] val, string tag);
        sbq.push_back('{cyc + dly, sel, val, tag});
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        push(0, S_CTRL, 16'h00, "R1");
        push(0, S_CNT,  16'h0,  "R1");
        push(0, S_TOUT, 16'h0,  "R1");
        push(0, S_IRQ,  16'h0,  "R1");
        drain();

        // R2: stopped, compare 0 equals count 0, strobes present: no irq
        cnt_en = 1'b1;
        wr(2'd1, 16'h0000);
        push(0, S_CNT, 16'h0, "R2");
        push(1, S_IRQ, 16'h0, "R2");
        push(2, S_IRQ, 16'h0, "R2");
        push(3, S_CNT, 16'h0, "R2");
        drain();

        // R3/R7/R8: free-running, cmp0=5 cmp1=3
        wr(2'd1, 16'd5);
        wr(2'd2, 16'd3);
        wr(2'd3, 16'h0001);
        wr(2'd0, 16'h0002);
        t0 = cyc;
        push(0, S_CTRL, 16'h02, "R10");
        push(0, S_CNT,  16'd0,  "R3");
        push(3, S_CNT,  16'd3,  "R3");
        push(3, S_IRQ,  16'h0,  "R7");
        push(4, S_IRQ,  16'h1,  "R7");
        push(4, S_TOUT, 16'h1,  "R8");
        push(5, S_IRQ,  16'h0,  "R7");
        push(6, S_IRQ,  16'h1,  "R7");
        push(6, S_TOUT, 16'h0,  "R8");
        push(7, S_CNT,  16'd7,  "R3");
        drain();
        // R10: non-stop mode code ignored while running
        wr(2'd0, 16'h0008);
        push(0, S_CTRL, 16'h02, "R10");
        push(0, S_CNT,  16'(cyc - t0), "R3");
        drain();
        // R3: strobe low holds count
        cnt_en = 1'b0;
        push(3, S_CNT, 16'(cyc - t0), "R3");
        drain();
        cnt_en = 1'b1;
        wr(2'd0, 16'h0000);
        push(0, S_CTRL, 16'h00, "R10");
        push(1, S_CNT,  16'h0,  "R2");
        push(2, S_CNT,  16'h0,  "R2");
        drain();

        // R4: clear on compare 0 match
        wr(2'd0, 16'h0008);
        push(0,  S_CTRL, 16'h08, "R10");
        push(4,  S_TOUT, 16'h1,  "R8");
        push(5,  S_CNT,  16'd5,  "R4");
        push(6,  S_CNT,  16'd0,  "R4");
        push(6,  S_IRQ,  16'h1,  "R7");
        push(6,  S_TOUT, 16'h0,  "R8");
        push(7,  S_CNT,  16'd1,  "R4");
        push(12, S_CNT,  16'd0,  "R4");
        drain();
        wr(2'd0, 16'h0000);
        push(1, S_CNT,  16'h0, "R2");
        push(3, S_TOUT, 16'h0, "R8");
        drain();

        // R8: both compares equal -> single toggle
        wr(2'd1, 16'd4);
        wr(2'd2, 16'd4);
        wr(2'd0, 16'h000A);
        push(5, S_IRQ,  16'h1, "R7");
        push(5, S_CNT,  16'd0, "R4");
        push(5, S_TOUT, 16'h1, "R8");
        push(6, S_TOUT, 16'h1, "R8");
        push(6, S_IRQ,  16'h0, "R7");
        drain();
        wr(2'd0, 16'h0000);
        drain();

        // R6/R8: free-running with edge output, falling select
        wr(2'd1, 16'd1000);
        wr(2'd2, 16'd2000);
        wr(2'd3, 16'h0000);
        wr(2'd0, 16'h0004);
        ext_in = 1'b1;
        push(4, S_TOUT, 16'h1, "R6");
        drain();
        ext_in = 1'b0;
        push(2, S_TOUT, 16'h1, "R8");
        push(3, S_TOUT, 16'h0, "R6");
        drain();
        wr(2'd3, 16'h0002);
        ext_in = 1'b1;
        push(3, S_TOUT, 16'h0, "R6");
        push(5, S_TOUT, 16'h0, "R6");
        drain();
        wr(2'd0, 16'h0000);
        drain();

        // R5/R6: clear on input edge, rising then both
        wr(2'd3, 16'h0001);
        ext_in = 1'b0;
        repeat (4) @(negedge clk);
        wr(2'd0, 16'h000C);
        ext_in = 1'b1;
        push(2, S_CNT,  16'd2, "R5");
        push(3, S_CNT,  16'd0, "R5");
        push(3, S_TOUT, 16'h0, "R8");
        push(4, S_CNT,  16'd1, "R5");
        drain();
        wr(2'd3, 16'h0003);
        ext_in = 1'b0;
        push(3, S_CNT, 16'd0, "R6");
        push(4, S_CNT, 16'd1, "R5");
        drain();
        wr(2'd0, 16'h0000);
        drain();

        // R9: compare-clear with compare 0 = FFFFH
        wr(2'd1, 16'hFFFF);
        wr(2'd0, 16'h0008);
        push(65535, S_CTRL, 16'h08,   "R9");
        push(65535, S_CNT,  16'hFFFF, "R9");
        push(65536, S_CNT,  16'h0000, "R9");
        push(65536, S_CTRL, 16'h09,   "R9");
        push(65536, S_IRQ,  16'h1,    "R7");
        push(65540, S_CTRL, 16'h09,   "R9");
        drain();
        // R10: clear overflow while running, mode change ignored
        wr(2'd0, 16'h000C);
        push(0, S_CTRL, 16'h08, "R10");
        drain();
        wr(2'd0, 16'h0000);
        push(0, S_CTRL, 16'h00, "R10");
        drain();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule